// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is a serial register slave. A host drives three lines: a serial clock, a serial data input and an active-low enable. Over these lines the host writes and reads a bank of byte-wide registers. The block returns read data on a serial output with a separate output-enable, so the pad can be tri-stated.

Every frame starts with a zero start bit, followed by a direction bit and a five-bit register address. A write frame then carries a data byte and two stop bits. A read frame instead shifts a byte back to the host. The enable may stay low across many frames.

Writes do not act at once. Each write lands in shadow storage, and all staged writes are copied into the live registers together when the enable returns high. The host can therefore change a group of settings as one atomic update.

The live register contents leave the block as one flat vector for the logic they control. Two read-only status bytes are supplied from outside the block.

The three serial inputs are asynchronous to the system clock. They are resynchronised, and their edges are detected in the system clock domain. The serial clock must therefore run well below the system clock.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset, every register byte on `live_regs` is 0x00 and `so_oe` is 0.
- R2: A write frame is made of the following bits, each sampled on a falling edge of `sck`:
  - a start bit of 0;
  - a direction bit of 0;
  - the 5-bit address, most significant bit first;
  - 8 data bits, most significant bit first;
  - two stop bits of 1.
  A frame that follows this format stages its byte for the addressed register.
- R3: Staged bytes leave `live_regs` unchanged until `en_n` rises. At that rise, every staged byte is copied to its live register.
- R4: Several frames may run inside one low period of `en_n`. All writes staged in that period commit together. When one address is written twice, the later byte wins.
- R5: A read frame is made of a start bit of 0, a direction bit of 1 and the 5-bit address, most significant bit first. The 8 register bits then appear on `so_o`, most significant bit first. The first bit is driven after the `sck` rising edge that follows the last address bit, and each further bit changes only after a rising edge.
- R6: `so_oe` is 1 only while the 8 read bits are being shifted out. At all other times it is 0.
- R7: Address 0 holds a single bit, which takes the most significant data bit of a write. It appears as bit 0 of `live_regs`, and bits 7..1 of that byte read as 0. A read of address 0 returns the stored bit as bit 7, with the other bits 0.
- R8: Addresses 12 and 13 are read-only status bytes. A read of address 12 returns `status_in[7:0]`, and a read of address 13 returns `status_in[15:8]`. Writes to these addresses are ignored, and their bytes on `live_regs` stay 0x00.
- R9: Addresses 23 to 31 hold no register. Writes to them are ignored, and reads from them return 0x00.
- R10: A write frame is discarded if either of its stop bits is 0.
- R11: If `en_n` goes high before a frame is complete, that frame is aborted and stages nothing. Complete frames staged earlier in the same enable period still commit.
- R12: Once a frame ends, a start bit is recognised only after `si` has been sampled as 1 at least once. A 0 sampled straight after a frame does not start a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host; idles high |
| si | input | 1 | Serial data from host; idles high |
| en_n | input | 1 | Active-low transaction enable; its rising edge commits staged writes |
| status_in | input | 16 | Status bytes for address 12 (low byte) and address 13 (high byte) |
| so_o | output | 1 | Serial read data |
| so_oe | output | 1 | Output enable for the serial read data pad |
| live_regs | output | 184 | Live register bytes; byte n sits at bits 8n+7..8n |

## Verification
The following are checked on every cycle:
- The live registers change only in the cycle after a commit, and the commit empties the staging state.
- A write to a status address or an unmapped address leaves the staging state untouched.
- The output enable can only begin on a serial clock rising edge, and it drops once the enable is released.
- A write is staged only while the enable was low.

Some behaviour can be shown only by the bench's scenarios. These include the exact bit framing, the byte read back from each address, the last-write-wins merge, discarding frames with bad stop bits, aborting a frame when the enable rises, and ignoring a start bit that arrives without the idle gap. In the gap scenario, a faulty slave would start a read frame that nobody asked for. The bench's per-cycle check of the output enable catches that.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_ADDR,
    ST_WDATA,
    ST_STOP,
    ST_RDATA,
    ST_GAP
  } tw_state_e;

  // An address may be staged only when it maps to storage that is not status.
  function automatic logic tw_is_writable(input int unsigned addr,
                                          input int unsigned nregs,
                                          input int unsigned stat_lo,
                                          input int unsigned stat_hi);
    return (addr < nregs) && (addr != stat_lo) && (addr != stat_hi);
  endfunction

  // Lowest bit position of register byte idx within the flat vector.
  function automatic int unsigned tw_lane(input int unsigned idx,
                                          input int unsigned width);
    return idx * width;
  endfunction

endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) pipe_q[i] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      pipe_q[0] <= d_in;
      for (int i = 1; i < int'(STAGES); i++) pipe_q[i] <= pipe_q[i-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl  = pipe_q[STAGES-1];
  assign rise = pipe_q[STAGES-1] & ~prev_q;
  assign fall = ~pipe_q[STAGES-1] & prev_q;

endmodule

// File: rtl/tw_frame_fsm.sv
module tw_frame_fsm
  import tw_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_low,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_lvl,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              so_o,
  output logic              so_oe,
  output logic              stage_pulse,
  output logic [ADDR_W-1:0] stage_addr,
  output logic [DATA_W-1:0] stage_data
);

  tw_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rd_q;
  logic              is_rd_q;
  logic              stop1_q;

  // Address as it will stand once the bit now on si is shifted in.
  assign rd_addr    = {addr_q[ADDR_W-2:0], si_lvl};
  assign stage_addr = addr_q;
  assign stage_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      rd_q        <= '0;
      is_rd_q     <= 1'b0;
      stop1_q     <= 1'b0;
      so_o        <= 1'b0;
      so_oe       <= 1'b0;
      stage_pulse <= 1'b0;
    end else if (!en_low) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      so_o        <= 1'b0;
      so_oe       <= 1'b0;
      stage_pulse <= 1'b0;
    end else begin
      stage_pulse <= 1'b0;
      if (sck_fall) begin
        unique case (state_q)
          ST_IDLE: if (!si_lvl) state_q <= ST_DIR;
          ST_DIR: begin
            is_rd_q <= si_lvl;
            cnt_q   <= '0;
            state_q <= ST_ADDR;
          end
          ST_ADDR: begin
            addr_q <= rd_addr;
            if (cnt_q == CNT_W'(ADDR_W - 1)) begin
              cnt_q <= '0;
              if (is_rd_q) begin
                rd_q    <= rd_byte;
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_WDATA;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WDATA: begin
            data_q <= {data_q[DATA_W-2:0], si_lvl};
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              cnt_q   <= '0;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == '0) begin
              stop1_q <= si_lvl;
              cnt_q   <= 1'b1;
            end else begin
              stage_pulse <= stop1_q & si_lvl;
              cnt_q       <= '0;
              state_q     <= ST_GAP;
            end
          end
          ST_GAP: if (si_lvl) state_q <= ST_IDLE;
          default: ;
        endcase
      end else if (sck_rise && state_q == ST_RDATA) begin
        if (cnt_q < CNT_W'(DATA_W)) begin
          so_o  <= rd_q[DATA_W-1];
          so_oe <= 1'b1;
          rd_q  <= {rd_q[DATA_W-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
        end else begin
          so_o    <= 1'b0;
          so_oe   <= 1'b0;
          cnt_q   <= '0;
          state_q <= ST_GAP;
        end
      end
    end
  end

endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_pkg::*;
#(
  parameter int unsigned NUM_REGS = 23,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned STAT_LO = 12,
  parameter int unsigned STAT_HI = 13,
  localparam int unsigned FLAT_W = NUM_REGS * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stage_pulse,
  input  logic [ADDR_W-1:0]   stage_addr,
  input  logic [DATA_W-1:0]   stage_data,
  input  logic                commit_pulse,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [2*DATA_W-1:0] status_in,
  output logic [DATA_W-1:0]   rd_byte,
  output logic [FLAT_W-1:0]   live_flat,
  output logic [NUM_REGS-1:0] pend_mask
);

  for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_reg
    if (g == int'(STAT_LO) || g == int'(STAT_HI)) begin : g_stat
      assign live_flat[tw_lane(g, DATA_W) +: DATA_W] = '0;
      assign pend_mask[g] = 1'b0;
    end else begin : g_rw
      logic [DATA_W-1:0] shadow_q;
      logic [DATA_W-1:0] live_q;
      logic              pend_q;
      logic              hit;
      logic [DATA_W-1:0] fold;

      assign hit  = stage_pulse && (int'(stage_addr) == g);
      // The single-bit register keeps only the leading data bit.
      assign fold = (g == 0) ? {{(DATA_W-1){1'b0}}, stage_data[DATA_W-1]}
                             : stage_data;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow_q <= '0;
          live_q   <= '0;
          pend_q   <= 1'b0;
        end else if (commit_pulse) begin
          if (pend_q) live_q <= shadow_q;
          pend_q <= 1'b0;
        end else if (hit) begin
          shadow_q <= fold;
          pend_q   <= 1'b1;
        end
      end

      assign live_flat[tw_lane(g, DATA_W) +: DATA_W] = live_q;
      assign pend_mask[g] = pend_q;
    end
  end

  always_comb begin
    int unsigned a;
    a = int'(rd_addr);
    rd_byte = '0;
    if (a == 0)            rd_byte = {live_flat[0], {(DATA_W-1){1'b0}}};
    else if (a == STAT_LO) rd_byte = status_in[DATA_W-1:0];
    else if (a == STAT_HI) rd_byte = status_in[2*DATA_W-1:DATA_W];
    else if (a < NUM_REGS) rd_byte = live_flat[tw_lane(a, DATA_W) +: DATA_W];
  end

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_pkg::*;
#(
  parameter int unsigned NUM_REGS = 23,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned STAT_LO = 12,
  parameter int unsigned STAT_HI = 13,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned FLAT_W = NUM_REGS * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                si,
  input  logic                en_n,
  input  logic [2*DATA_W-1:0] status_in,
  output logic                so_o,
  output logic                so_oe,
  output logic [FLAT_W-1:0]   live_regs
);

  logic [2:0] pin_lvl, pin_rise, pin_fall;

  tw_edge_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in ({en_n, si, sck}),
    .lvl  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  // Named internal events, watched by the bound checker.
  logic                en_low, sck_rise, sck_fall, si_lvl, commit_pulse;
  logic                stage_pulse;
  logic [ADDR_W-1:0]   stage_addr, rd_addr;
  logic [DATA_W-1:0]   stage_data, rd_byte;
  logic [NUM_REGS-1:0] pend_mask;
  logic [FLAT_W-1:0]   live_flat;
  logic                unused_edges;

  assign en_low       = ~pin_lvl[2];
  assign commit_pulse = pin_rise[2];
  assign si_lvl       = pin_lvl[1];
  assign sck_rise     = pin_rise[0];
  assign sck_fall     = pin_fall[0];
  assign unused_edges = ^{pin_fall[2:1], pin_rise[1], pin_lvl[0]};

  tw_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_low     (en_low),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .si_lvl     (si_lvl),
    .rd_byte    (rd_byte),
    .rd_addr    (rd_addr),
    .so_o       (so_o),
    .so_oe      (so_oe),
    .stage_pulse(stage_pulse),
    .stage_addr (stage_addr),
    .stage_data (stage_data)
  );

  tw_reg_bank #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .STAT_LO(STAT_LO), .STAT_HI(STAT_HI)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_pulse (stage_pulse),
    .stage_addr  (stage_addr),
    .stage_data  (stage_data),
    .commit_pulse(commit_pulse),
    .rd_addr     (rd_addr),
    .status_in   (status_in),
    .rd_byte     (rd_byte),
    .live_flat   (live_flat),
    .pend_mask   (pend_mask)
  );

  assign live_regs = live_flat;

endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk
  import tw_pkg::*;
#(
  parameter int unsigned NUM_REGS = 23,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned STAT_LO = 12,
  parameter int unsigned STAT_HI = 13
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         en_low,
  input logic                         sck_rise,
  input logic                         so_oe,
  input logic                         commit_pulse,
  input logic                         stage_pulse,
  input logic [ADDR_W-1:0]            stage_addr,
  input logic [NUM_REGS*DATA_W-1:0]   live_flat,
  input logic [NUM_REGS-1:0]          pend_mask
);

  // R3: live contents move only on the cycle after a commit event
  assert_live_only_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |=> $stable(live_flat));

  // R3: a commit leaves nothing staged
  assert_commit_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> (pend_mask == '0));

  // R8 / R9: status and unmapped addresses never reach the staging state
  assert_no_stage_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_pulse && !tw_is_writable(int'(stage_addr), NUM_REGS, STAT_LO, STAT_HI))
      |=> $stable(pend_mask));

  // R5: read output starts only on a serial clock rising edge
  assert_oe_starts_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(sck_rise));

  // R6: releasing the enable turns the output driver off
  assert_oe_off_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_low) |=> !so_oe);

  // R11: staging only happens for a frame completed inside an enable period
  assert_stage_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stage_pulse |-> $past(en_low));

endmodule

bind tw_reg_slave tw_reg_slave_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .STAT_LO(STAT_LO), .STAT_HI(STAT_HI)
) u_tw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_low      (en_low),
  .sck_rise    (sck_rise),
  .so_oe       (so_oe),
  .commit_pulse(commit_pulse),
  .stage_pulse (stage_pulse),
  .stage_addr  (stage_addr),
  .live_flat   (live_flat),
  .pend_mask   (pend_mask)
);

// File: tb/test_tw_reg_slave.sv
module test_tw_reg_slave;
  localparam int NR = 23;
  localparam int DW = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1;
  logic si = 1'b1;
  logic en_n = 1'b1;
  logic [15:0] status_in = 16'hC35E;
  wire so_o, so_oe;
  wire [NR*DW-1:0] live_regs;

  always #2 clk = ~clk;

  tw_reg_slave i_tw_reg_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .en_n(en_n),
    .status_in(status_in), .so_o(so_o), .so_oe(so_oe), .live_regs(live_regs)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit hold = 1'b1;
  bit reading = 1'b0;
  int live_m[NR];
  int shad_m[NR];
  bit pend_m[NR];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int live_slot(input int a);
    return int'(live_regs[a*DW +: DW]);
  endfunction

  function automatic bit model_writable(input int a);
    return a >= 0 && a < NR && a != 12 && a != 13;
  endfunction

  function automatic int model_read(input int a);
    if (a == 0) return live_m[0] << 7;
    if (a == 12) return int'(status_in[7:0]);
    if (a == 13) return int'(status_in[15:8]);
    if (a < NR) return live_m[a];
    return 0;
  endfunction

  task automatic model_stage(input int a, input int d);
    if (model_writable(a)) begin
      shad_m[a] = (a == 0) ? ((d >> 7) & 1) : d;
      pend_m[a] = 1'b1;
    end
  endtask

  task automatic model_commit();
    for (int a = 0; a < NR; a++) begin
      if (pend_m[a]) live_m[a] = shad_m[a];
      pend_m[a] = 1'b0;
    end
  endtask

  // Reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !hold) begin
      bit ok;
      int bad;
      ok = 1'b1;
      bad = 0;
      for (int a = 0; a < NR; a++)
        if (ok && live_slot(a) != live_m[a]) begin ok = 1'b0; bad = a; end
      check(ok, "R3 live register matches reference", live_slot(bad), live_m[bad]);
    end
    if (rst_n && !reading)
      check(!so_oe, "R6 so_oe low outside read", int'(so_oe), 0);
  end

  task automatic sbit(input bit b);
    si = b;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) sbit(1'b1);
  endtask

  task automatic open_win();
    @(negedge clk);
    en_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic close_win();
    @(negedge clk);
    hold = 1'b1;
    si = 1'b1;
    en_n = 1'b1;
    repeat (8) @(negedge clk);
    model_commit();
    hold = 1'b0;
  endtask

  task automatic frame_write(input int a, input int d, input bit s1, input bit s2,
                             input int gap);
    sbit(1'b0);
    sbit(1'b0);
    for (int i = 4; i >= 0; i--) sbit(1'((a >> i) & 1));
    for (int i = 7; i >= 0; i--) sbit(1'((d >> i) & 1));
    sbit(s1);
    sbit(s2);
    if (s1 && s2) model_stage(a, d);
    idle_bits(gap);
  endtask

  task automatic frame_read(input int a, input string req);
    int got;
    int exp;
    exp = model_read(a);
    got = 0;
    reading = 1'b1;
    sbit(1'b0);
    sbit(1'b1);
    for (int i = 4; i >= 0; i--) sbit(1'((a >> i) & 1));
    for (int i = 0; i < 8; i++) begin
      si = 1'b1;
      repeat (HALF) @(negedge clk);
      check(so_oe, "R6 so_oe high during read bit", int'(so_oe), 1);
      got = (got << 1) | int'(so_o);
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
    end
    idle_bits(2);
    repeat (4) @(negedge clk);
    reading = 1'b0;
    check(got == exp, req, got, exp);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NR; a++) begin live_m[a] = 0; shad_m[a] = 0; pend_m[a] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    begin
      bit ok;
      ok = 1'b1;
      for (int a = 0; a < NR; a++) if (live_slot(a) != 0) ok = 1'b0;
      check(ok, "R1 all registers zero after reset", ok ? 0 : 1, 0);
      check(!so_oe, "R1 so_oe low after reset", int'(so_oe), 0);
    end
    hold = 1'b0;

    // R2 / R3: single write, deferred commit
    open_win();
    frame_write(1, 8'hA5, 1, 1, 1);
    repeat (10) @(negedge clk);
    check(live_slot(1) == 0, "R3 no change before enable rises", live_slot(1), 0);
    close_win();
    check(live_slot(1) == 8'hA5, "R2 write committed", live_slot(1), 8'hA5);

    // R4: back-to-back frames, last write wins
    open_win();
    frame_write(5, 8'h3C, 1, 1, 1);
    frame_write(14, 8'h11, 1, 1, 1);
    frame_write(14, 8'h99, 1, 1, 1);
    frame_write(22, 8'hFF, 1, 1, 1);
    close_win();
    check(live_slot(14) == 8'h99, "R4 later write wins", live_slot(14), 8'h99);
    check(live_slot(5) == 8'h3C, "R4 grouped commit", live_slot(5), 8'h3C);
    check(live_slot(22) == 8'hFF, "R4 grouped commit top", live_slot(22), 8'hFF);

    // R5: reads, several patterns
    open_win();
    frame_read(14, "R5 read address 14");
    frame_read(22, "R5 read address 22");
    frame_read(1, "R5 read address 1");
    close_win();

    // R7: one-bit register
    open_win();
    frame_write(0, 8'h80, 1, 1, 1);
    close_win();
    check(live_slot(0) == 1, "R7 address 0 keeps MSB", live_slot(0), 1);
    open_win();
    frame_read(0, "R7 read address 0");
    frame_write(0, 8'h7F, 1, 1, 1);
    close_win();
    check(live_slot(0) == 0, "R7 address 0 ignores low bits", live_slot(0), 0);

    // R8: status bytes
    open_win();
    frame_read(12, "R8 read status low");
    frame_read(13, "R8 read status high");
    frame_write(12, 8'hAA, 1, 1, 1);
    frame_write(13, 8'h55, 1, 1, 1);
    close_win();
    check(live_slot(12) == 0, "R8 status slot 12 stays zero", live_slot(12), 0);
    status_in = 16'h0F96;
    open_win();
    frame_read(12, "R8 status low after write attempt");
    frame_read(13, "R8 status high after write attempt");
    close_win();

    // R9: unmapped addresses
    open_win();
    frame_write(23, 8'h12, 1, 1, 1);
    frame_write(31, 8'h34, 1, 1, 1);
    frame_read(31, "R9 read unmapped");
    frame_read(23, "R9 read unmapped 23");
    close_win();

    // R10: bad stop bits
    open_win();
    frame_write(2, 8'h77, 1, 0, 1);
    frame_write(2, 8'h66, 0, 1, 1);
    close_win();
    check(live_slot(2) == 0, "R10 bad stop discarded", live_slot(2), 0);

    // R11: abort mid-frame
    open_win();
    frame_write(3, 8'h5A, 1, 1, 1);
    sbit(1'b0); sbit(1'b0);
    sbit(1'b0); sbit(1'b0); sbit(1'b1); sbit(1'b0); sbit(1'b0);
    sbit(1'b1); sbit(1'b1);
    close_win();
    check(live_slot(3) == 8'h5A, "R11 earlier frame commits", live_slot(3), 8'h5A);
    check(live_slot(4) == 0, "R11 aborted frame dropped", live_slot(4), 0);

    // R12: start without idle gap is ignored
    open_win();
    frame_write(6, 8'h42, 1, 1, 0);
    sbit(1'b0);
    sbit(1'b1);
    idle_bits(10);
    frame_write(7, 8'hC7, 1, 1, 1);
    close_win();
    check(live_slot(6) == 8'h42, "R12 frame before gap", live_slot(6), 8'h42);
    check(live_slot(7) == 8'hC7, "R12 frame after gap", live_slot(7), 8'hC7);

    repeat (10) @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end

endmodule